// File: doc/BRIEF.md
# Xon/Xoff Software Flow Control Detector

This block watches the byte stream coming out of a UART receiver and looks for in-band flow control characters. When the far end sends its stop sequence, the local transmitter is told to pause. The pause takes effect once the character now on the line has finished. When the far end later sends its go sequence, the pause is lifted. A sticky status flag, and an interrupt gated by an enable, report that a stop sequence arrived.

Four writable character registers hold the sequences, one pair for stopping and one pair for resuming. In single-character mode only the first register of each pair is compared. In double-character mode the two registers of a pair must be matched by two consecutive received bytes. The transmitter reports through a busy level and a character-done strobe. The block returns a hold level that the transmitter samples between characters.

Top module: `swfc_detector`

## Requirements
- R1: The four character registers reset to 0x00. A write with `cfg_we` high stores `cfg_wdata` at the edge, at `cfg_addr` 0 = first go, 1 = second go, 2 = first stop, 3 = second stop. A byte received in the same cycle is still compared with the old value.
- R2: With `dbl_mode` low, a received byte equal to the first stop register is a stop match. A byte equal to the first go register is a go match. When a byte equals both registers, the stop match wins.
- R3: With `dbl_mode` high, a stop match needs two consecutive received bytes equal to the first and then the second stop register. A go match needs the same with the go registers. Cycles in which `rx_valid` is low do not break a pair. When both pairs complete on the same byte, the stop pair wins.
- R4: After a stop match, `tx_hold` rises on the same clock edge if `tx_busy` was low or `tx_done` was high in the matching cycle. Otherwise it rises on the edge at which `tx_done` is seen high. It stays high until the suspension ends.
- R5: A stop match sets `xoff_flag` on the matching edge. `irq` equals `xoff_flag` AND `irq_en`.
- R6: A go match while suspended ends the suspension. On that edge both `tx_hold` and `xoff_flag` drop.
- R7: In double mode, a byte that does not complete a pending pair discards the partial match. That same byte is then tested as a possible first byte of either pair.
- R8: While `fc_en` is low, `tx_hold` is low combinationally and no matching takes place. Any suspension and any partial match are cleared, so raising `fc_en` again does not bring back a hold.
- R9: A go match while not suspended leaves `tx_hold` and `xoff_flag` unchanged.
- R10: `flag_clr` clears `xoff_flag` without ending the suspension. A stop match in the same cycle takes precedence and keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | DATA_W | Received byte |
| cfg_we | input | 1 | Character register write enable |
| cfg_addr | input | 2 | Character register select |
| cfg_wdata | input | DATA_W | Character register write data |
| fc_en | input | 1 | Software flow control enable |
| dbl_mode | input | 1 | 1 = two-character sequences, 0 = single character |
| irq_en | input | 1 | Interrupt enable for the stop-received flag |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_done | input | 1 | One-cycle strobe: the current character has completed |
| flag_clr | input | 1 | Clears the stop-received flag |
| tx_hold | output | 1 | Transmitter must not start a new character |
| xoff_flag | output | 1 | Sticky stop-received status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 8-bit character width. It programs the registers only from a small pool of values, so the go and stop registers often collide with each other and with the received bytes. This brings the priority rules, double-mode re-evaluation after a broken pair, and go bytes arriving while not suspended within reach of random stimulus. The transmitter busy and done inputs are randomised independently, so a hold can be requested both while the transmitter is idle and while it is in mid-character.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int unsigned SWFC_NUM_CHARS = 4;
  localparam int unsigned SWFC_AW = $clog2(SWFC_NUM_CHARS);

  typedef enum logic [SWFC_AW-1:0] {
    IDX_GO1   = 2'd0,
    IDX_GO2   = 2'd1,
    IDX_STOP1 = 2'd2,
    IDX_STOP2 = 2'd3
  } swfc_idx_e;

  typedef struct packed {
    logic go;
    logic stop;
  } swfc_hit_t;
endpackage

// File: rtl/swfc_char_regs.sv
module swfc_char_regs
  import swfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [SWFC_AW-1:0]                   addr,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [SWFC_NUM_CHARS-1:0][DATA_W-1:0] chars
);
  for (genvar gi = 0; gi < SWFC_NUM_CHARS; gi++) begin : g_ch
    logic              en;
    logic [DATA_W-1:0] q;

    assign en = we && (addr == SWFC_AW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end

    assign chars[gi] = q;

    // R1
    char_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == SWFC_AW'(gi)) |=> (chars[gi] == $past(wdata)));
  end
endmodule

// File: rtl/swfc_matcher.sv
module swfc_matcher
  import swfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fc_en,
  input  logic                                 dbl_mode,
  input  logic                                 rx_valid,
  input  logic [DATA_W-1:0]                    rx_data,
  input  logic [SWFC_NUM_CHARS-1:0][DATA_W-1:0] chars,
  output swfc_hit_t                            hit
);
  logic eq_go1, eq_go2, eq_stop1, eq_stop2;
  logic pend_go_q, pend_go_d, pend_stop_q, pend_stop_d;

  assign eq_go1   = (rx_data == chars[IDX_GO1]);
  assign eq_go2   = (rx_data == chars[IDX_GO2]);
  assign eq_stop1 = (rx_data == chars[IDX_STOP1]);
  assign eq_stop2 = (rx_data == chars[IDX_STOP2]);

  always_comb begin
    hit         = '0;
    pend_go_d   = pend_go_q;
    pend_stop_d = pend_stop_q;
    if (!fc_en || !dbl_mode) begin
      pend_go_d   = 1'b0;
      pend_stop_d = 1'b0;
      if (fc_en && rx_valid) begin
        hit.stop = eq_stop1;
        hit.go   = !eq_stop1 && eq_go1;
      end
    end else if (rx_valid) begin
      if (pend_stop_q && eq_stop2) begin
        hit.stop    = 1'b1;
        pend_go_d   = 1'b0;
        pend_stop_d = 1'b0;
      end else if (pend_go_q && eq_go2) begin
        hit.go      = 1'b1;
        pend_go_d   = 1'b0;
        pend_stop_d = 1'b0;
      end else begin
        pend_stop_d = eq_stop1;
        pend_go_d   = eq_go1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_go_q   <= 1'b0;
      pend_stop_q <= 1'b0;
    end else begin
      pend_go_q   <= pend_go_d;
      pend_stop_q <= pend_stop_d;
    end
  end

  // R8
  hit_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.go || hit.stop) |-> (rx_valid && fc_en));

  // R3
  dbl_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl_mode && (hit.go || hit.stop)) |-> (pend_go_q || pend_stop_q));
endmodule

// File: rtl/swfc_hold_ctrl.sv
module swfc_hold_ctrl
  import swfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fc_en,
  input  swfc_hit_t hit,
  input  logic      tx_busy,
  input  logic      tx_done,
  input  logic      flag_clr,
  input  logic      irq_en,
  output logic      tx_hold,
  output logic      xoff_flag,
  output logic      irq
);
  logic susp_q, susp_d;
  logic flag_q, flag_d;
  logic hold_q, hold_d;

  always_comb begin
    susp_d = susp_q;
    if (!fc_en)        susp_d = 1'b0;
    else if (hit.stop) susp_d = 1'b1;
    else if (hit.go)   susp_d = 1'b0;

    flag_d = flag_q;
    if (hit.stop)                flag_d = 1'b1;
    else if (hit.go && susp_q)   flag_d = 1'b0;
    else if (flag_clr)           flag_d = 1'b0;

    hold_d = susp_d && (hold_q || !tx_busy || tx_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      susp_q <= susp_d;
      flag_q <= flag_d;
      hold_q <= hold_d;
    end
  end

  assign tx_hold   = hold_q && fc_en;
  assign xoff_flag = flag_q;
  assign irq       = flag_q && irq_en;

  // R4
  hold_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(!tx_busy || tx_done));

  // R5
  flag_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit.stop));

  // R6
  resume_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(susp_q) |-> $past(hit.go || !fc_en));

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> !susp_q);
endmodule

// File: rtl/swfc_detector.sv
module swfc_detector
  import swfc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              fc_en,
  input  logic              dbl_mode,
  input  logic              irq_en,
  input  logic              tx_busy,
  input  logic              tx_done,
  input  logic              flag_clr,
  output logic              tx_hold,
  output logic              xoff_flag,
  output logic              irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SWFC_NUM_CHARS-1:0][DATA_W-1:0] chars;
  swfc_hit_t                             hit;

  swfc_char_regs #(.DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .chars (chars)
  );

  swfc_matcher #(.DATA_W(DATA_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fc_en    (fc_en),
    .dbl_mode (dbl_mode),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .chars    (chars),
    .hit      (hit)
  );

  swfc_hold_ctrl u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .fc_en     (fc_en),
    .hit       (hit),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .tx_hold   (tx_hold),
    .xoff_flag (xoff_flag),
    .irq       (irq)
  );

  // R9
  no_hold_without_flag_path_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hit.go && !tx_hold && !xoff_flag) |=> !xoff_flag);
endmodule

// File: tb/swfc_detector_tb.sv
module swfc_detector_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, cfg_we, fc_en, dbl_mode, irq_en, tx_busy, tx_done, flag_clr;
  logic [7:0] rx_data, cfg_wdata;
  logic [1:0] cfg_addr;
  logic       tx_hold, xoff_flag, irq;

  always #5 clk = ~clk;

  swfc_detector #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fc_en(fc_en), .dbl_mode(dbl_mode), .irq_en(irq_en),
    .tx_busy(tx_busy), .tx_done(tx_done), .flag_clr(flag_clr),
    .tx_hold(tx_hold), .xoff_flag(xoff_flag), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [7:0] m_reg [4];
  bit m_pgo, m_pstop, m_susp, m_flag, m_hold;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, "tx_hold", tx_hold, m_hold & fc_en);
    chk(tag, "xoff_flag", xoff_flag, m_flag);
    chk(tag, "irq", irq, m_flag & irq_en);
  endtask

  task automatic step(input bit v, input logic [7:0] d, input bit we, input logic [1:0] a,
                      input logic [7:0] wd, input bit en, input bit dbl, input bit ie,
                      input bit busy, input bit dn, input bit clr, input string tag);
    bit hgo, hstop, npgo, npstop, nsusp, nflag, nhold;
    @(negedge clk);
    rx_valid = v; rx_data = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    fc_en = en; dbl_mode = dbl; irq_en = ie; tx_busy = busy; tx_done = dn; flag_clr = clr;
    #1;
    if (!en) chk(tag, "tx_hold_comb", tx_hold, 1'b0);
    hgo = 0; hstop = 0; npgo = m_pgo; npstop = m_pstop;
    if (!en || !dbl) begin
      npgo = 0; npstop = 0;
      if (en && v) begin
        hstop = (d == m_reg[2]);
        hgo   = !hstop && (d == m_reg[0]);
      end
    end else if (v) begin
      if (m_pstop && d == m_reg[3]) begin hstop = 1; npgo = 0; npstop = 0; end
      else if (m_pgo && d == m_reg[1]) begin hgo = 1; npgo = 0; npstop = 0; end
      else begin npstop = (d == m_reg[2]); npgo = (d == m_reg[0]); end
    end
    nsusp = !en ? 1'b0 : hstop ? 1'b1 : hgo ? 1'b0 : m_susp;
    nflag = hstop ? 1'b1 : (hgo && m_susp) ? 1'b0 : clr ? 1'b0 : m_flag;
    nhold = nsusp && (m_hold || !busy || dn);
    @(posedge clk);
    #1;
    m_pgo = npgo; m_pstop = npstop; m_susp = nsusp; m_flag = nflag; m_hold = nhold;
    if (we) m_reg[a] = wd;
    check_outs(tag);
  endtask

  task automatic rx(input logic [7:0] d, input bit dbl, input string tag);
    step(1, d, 0, 0, 0, 1, dbl, 1, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] wd);
    step(0, 0, 1, a, wd, 1, 0, 1, 0, 0, 0, "R1");
  endtask

  function automatic logic [7:0] pick(input logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h13;
      3'd2: return 8'h12;
      3'd3: return 8'h14;
      default: return 8'h55;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C11));
    rst_n = 0; rx_valid = 0; rx_data = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    fc_en = 1; dbl_mode = 0; irq_en = 1; tx_busy = 0; tx_done = 0; flag_clr = 0;
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
    m_pgo = 0; m_pstop = 0; m_susp = 0; m_flag = 0; m_hold = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_outs("R1");

    // R1: all registers zero, byte 0x00 matches stop (and go), stop wins (R2)
    rx(8'h00, 0, "R1");
    // R10: clear flag, hold stays
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 1, "R10");
    wr(2'd0, 8'h11); wr(2'd1, 8'h12); wr(2'd2, 8'h13); wr(2'd3, 8'h14);
    rx(8'h11, 0, "R6");
    rx(8'h11, 0, "R9");
    // R4: stop while transmitter busy
    step(1, 8'h13, 0, 0, 0, 1, 0, 1, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R5");
    rx(8'h11, 0, "R6");
    // R3 / R7: double mode
    rx(8'h13, 1, "R7");
    rx(8'h55, 1, "R7");
    rx(8'h14, 1, "R7");
    rx(8'h13, 1, "R3");
    step(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R3");
    rx(8'h14, 1, "R3");
    rx(8'h11, 1, "R7");
    rx(8'h13, 1, "R7");
    rx(8'h11, 1, "R7");
    rx(8'h12, 1, "R3");
    // R8: disable clears suspension
    rx(8'h13, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R8");
    rx(8'h13, 0, "R2");
    rx(8'h11, 0, "R2");
    // R1: write during receive uses old value
    step(1, 8'h13, 1, 2'd2, 8'h20, 1, 0, 1, 0, 0, 0, "R1");
    rx(8'h20, 0, "R1");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0)
        step(0, 0, 1, r[5:4], pick(r[8:6]), r[12:9] != 0, r[13], r[14], r[15], r[16], 0, "RND");
      else
        step(r[17] | r[18], (r[19] | r[20]) ? pick(r[23:21]) : r[31:24], 0, 0, 0,
             r[12:9] != 0, (n / 300) % 2 == 1, r[14], r[15], r[16] & r[17], r[26:24] == 0, "RND");
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule